// File: doc/BRIEF.md
# Inrush Current Pulse Controller

This block selects the current level that a high-voltage input sink is told to draw. It can command either a large inrush level or a smaller bias level. It watches one comparator flag, which says whether the input is currently delivering the demanded current. From that flag it decides how long the inrush level is held and when to fall back to bias. An inrush pulse is timed only while the input can actually sustain it. Any dropout restarts the sequence from the beginning, so a bouncing contact never earns a shortened pulse.

A separate pulse limiter can assert an inhibit. While the inhibit is high, no new pulse may begin and the bias level is commanded. There is no data stream here: every pin is a plain level-sensitive control or status line with no handshake. The comparator flag is asynchronous and is synchronized inside the block. The inhibit and the duration value are expected to be synchronous to the clock.

Top module: `inrush_pulse_ctrl`

## Requirements
- R1: After reset, level_inrush is 1 (inrush commanded) and inrush_on is 0 (timer cleared).
- R2: supply_ok_async passes through two flops before use. After it rises, the earliest clock edge at which inrush_on can go high is the third edge.
- R3: While the synchronized supply flag is 0 and limit_inhibit is 0, level_inrush stays 1 and inrush_on stays 0, whatever the previous state was.
- R4: While the supply flag stays 1, inrush_on is high for exactly inrush_len consecutive cycles. After that, level_inrush becomes 0 (bias level).
- R5: An inrush_len of 0 gives the same result as 1: a one-cycle pulse.
- R6: If the supply flag drops while inrush_on is high, inrush_on goes low and level_inrush stays 1. The next pulse lasts the full inrush_len again.
- R7: If the supply flag drops while at bias level, level_inrush returns to 1 and inrush_on stays 0 until the supply returns.
- R8: While limit_inhibit is 1, level_inrush is 0 and inrush_on is 0 from the next edge on. No pulse starts, even with supply present. After release, the block waits at inrush level, and a pulse starts one edge later if the supply is present.
- R9: The bias level is entered only at the end of a running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok_async | input | 1 | Comparator flag: demanded current is being met (asynchronous) |
| inrush_len | input | DUR_W | Inrush pulse length in clock cycles |
| limit_inhibit | input | 1 | Pulse limiter inhibit, synchronous |
| level_inrush | output | 1 | 1 = inrush level commanded, 0 = bias level |
| inrush_on | output | 1 | High while the inrush timer runs |

## Verification
The hardest case is a supply dropout partway through a running pulse, followed by a full-length pulse. This is the case that tells a true timer restart apart from a timer that only pauses. The bench raises the supply flag, waits a counted number of edges (the two sync stages included) so the pulse is mid-run, and drops the flag. It then raises the flag again and measures the whole new pulse against inrush_len. The inhibit path is reached by asserting the inhibit with the supply present and confirming that no pulse appears until release.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_RUN  = 2'd1,
    ST_BIAS = 2'd2,
    ST_LOCK = 2'd3
  } ipc_state_t;
endpackage

// File: rtl/ipc_sync.sv
module ipc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ipc_timer.sv
module ipc_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DUR_W-1:0] limit,
  output logic             expired
);
  localparam logic [DUR_W-1:0] CNT_ONE = DUR_W'(1);
  localparam logic [DUR_W-1:0] CNT_MAX = {DUR_W{1'b1}};

  logic [DUR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= CNT_ONE;
    else if (clear)          cnt <= CNT_ONE;
    else if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
  end

  assign expired = (cnt >= limit);

  // R6: a cleared timer always restarts from the first count
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == CNT_ONE));
endmodule

// File: rtl/ipc_fsm.sv
module ipc_fsm
  import ipc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic inhibit,
  input  logic expired,
  output logic timer_clear,
  output logic level_inrush,
  output logic inrush_on
);
  ipc_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    if (inhibit) begin
      state_nx = ST_LOCK;
    end else begin
      unique case (state)
        ST_LOCK: state_nx = ST_ARM;
        ST_ARM:  if (supply_ok) state_nx = ST_RUN;
        ST_RUN: begin
          if (!supply_ok)   state_nx = ST_ARM;
          else if (expired) state_nx = ST_BIAS;
        end
        ST_BIAS: if (!supply_ok) state_nx = ST_ARM;
        default: state_nx = ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ARM;
    else        state <= state_nx;
  end

  assign timer_clear  = (state != ST_RUN);
  assign inrush_on    = (state == ST_RUN);
  assign level_inrush = (state == ST_ARM) || (state == ST_RUN);

  // R3
  no_supply_inrush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !inhibit) |=> (level_inrush && !inrush_on));

  // R8
  inhibit_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (!level_inrush && !inrush_on));

  // R4
  active_means_inrush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inrush_on |-> level_inrush);

  // R9
  bias_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_BIAS) |-> ($past(state) == ST_RUN));
endmodule

// File: rtl/inrush_pulse_ctrl.sv
module inrush_pulse_ctrl #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_async,
  input  logic [DUR_W-1:0] inrush_len,
  input  logic             limit_inhibit,
  output logic             level_inrush,
  output logic             inrush_on
);
  localparam int SYNC_STAGES = 2;

  logic supply_ok;
  logic expired;
  logic timer_clear;

  ipc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (supply_ok_async),
    .q_sync  (supply_ok)
  );

  ipc_timer #(.DUR_W(DUR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (timer_clear),
    .limit   (inrush_len),
    .expired (expired)
  );

  ipc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .inhibit      (limit_inhibit),
    .expired      (expired),
    .timer_clear  (timer_clear),
    .level_inrush (level_inrush),
    .inrush_on    (inrush_on)
  );
endmodule

// File: tb/test_inrush_pulse_ctrl.sv
module test_inrush_pulse_ctrl;
  localparam int DUR_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sup = 1'b0;
  logic [DUR_W-1:0] len = '0;
  logic             inh = 1'b0;
  logic             lvl, act;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  inrush_pulse_ctrl #(.DUR_W(DUR_W)) i_inrush_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok_async(sup), .inrush_len(len),
    .limit_inhibit(inh), .level_inrush(lvl), .inrush_on(act)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Raise supply and measure one pulse; expects exp_len active cycles then bias
  task automatic run_pulse(input string req, input int exp_len);
    int n;
    sup = 1'b1;
    step(2);
    chk("R2 not yet active", act, 0);
    step(1);
    chk("R2 active on third edge", act, 1);
    n = 1;
    for (int i = 0; i < 1000; i++) begin
      step(1);
      if (!act) break;
      n++;
    end
    chk({req, " pulse length"}, n, exp_len);
    chk({req, " bias after pulse"}, lvl, 0);
  endtask

  task automatic t_reset();
    chk("R1 level after reset", lvl, 1);
    chk("R1 active after reset", act, 0);
  endtask

  task automatic t_normal();
    len = 16'd5;
    run_pulse("R4 len5", 5);
    len = 16'd12;
    sup = 1'b0;
    step(3);
    chk("R7 back to inrush", lvl, 1);
    run_pulse("R4 len12", 12);
  endtask

  task automatic t_zero();
    sup = 1'b0;
    step(3);
    len = 16'd0;
    run_pulse("R5 len0", 1);
    sup = 1'b0;
    step(3);
    len = 16'd1;
    run_pulse("R5 len1", 1);
  endtask

  task automatic t_bounce();
    sup = 1'b0;
    step(3);
    len = 16'd8;
    sup = 1'b1;
    step(5);
    chk("R6 mid pulse active", act, 1);
    sup = 1'b0;
    step(3);
    chk("R6 dropout clears active", act, 0);
    chk("R6 dropout keeps inrush", lvl, 1);
    run_pulse("R6 full restart", 8);
  endtask

  task automatic t_bias_loss();
    sup = 1'b0;
    step(3);
    chk("R7 inrush after bias loss", lvl, 1);
    chk("R7 not active", act, 0);
    step(10);
    chk("R3 stays inrush", lvl, 1);
    chk("R3 stays idle", act, 0);
  endtask

  task automatic t_inhibit();
    int seen;
    len = 16'd4;
    inh = 1'b1;
    step(1);
    chk("R8 bias under inhibit", lvl, 0);
    sup = 1'b1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (act || lvl) seen++;
    end
    chk("R8 no pulse under inhibit", seen, 0);
    inh = 1'b0;
    step(1);
    chk("R8 release waits at inrush", lvl, 1);
    chk("R8 release not active yet", act, 0);
    step(1);
    chk("R8 pulse starts after release", act, 1);
    step(4);
    chk("R8 pulse ends to bias", lvl, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_normal();
    t_zero();
    t_bounce();
    t_bias_loss();
    t_inhibit();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule